// File: doc/BRIEF.md
# Serial NOR Flash Program Sequencer

This block writes one to four data bytes into a serial NOR flash over a single-bit SPI link, clock idle low, data sampled on the rising clock edge, most significant bit first. The host raises `start` for one cycle with an address, the data word and a length code. The block then runs the whole write sequence on its own. First comes a one-byte write-enable frame. Then comes a program frame carrying the opcode, the address and the data. Last, it reads the status register in repeated frames until the device reports that its internal write has finished.

The block applies a failure timeout while it polls. The timeout is derived from the worst-case page-program time and a scale factor given in tenths, for example 2.5x to 4x. When the sequence ends, the block pulses `done` for one cycle and presents a result code. Between any two frames, chip select stays high for at least a programmable number of serial-clock divider ticks.

A build-time option selects 4-byte addressing. With it set, the block leaves reset busy and sends write-enable and then the enter-4-byte-address command, once. After that, every program frame carries four address bytes.

Top module: `spi_nor_prog_seq`

## Requirements
- R1: After reset with 3-byte addressing, `spi_cs_n` is 1, `spi_sclk` is 0, `busy` is 0, `done` is 0 and `result` is 0.
- R2: Each accepted `start` first produces a frame holding only the byte 0x06.
- R3: The next frame is 0x02, then the address bytes most significant first (3-byte mode uses `addr[23:0]`), then `dlen`+1 data bytes, with `wdata[7:0]` first and each following higher byte after it.
- R4: Chip select rises only after a whole number of bytes. `spi_sclk` is low whenever `spi_cs_n` is high.
- R5: After the program frame, two-byte frames of 0x05 are sent repeatedly until a returned status byte has bit 0 (write in progress) clear. If the device reports busy N times, exactly N+1 status frames are sent.
- R6: If bit 0 is still set once PROG_MAX_CYC*TO_SCALE_X10/10 clock cycles have passed since the program frame ended, the sequence ends with `result` = 2'b01. `done` then comes no earlier than that limit and within one status-frame period after it.
- R7: When bit 0 reads clear, `result` is 2'b10 if status bit 1 (write-enable latch) is set and 2'b00 if it is clear. `result` changes only in a cycle where `done` is high.
- R8: Between consecutive frames, chip select stays high for at least CS_GAP_TICKS*CLK_DIV clock cycles.
- R9: A `start` received while `busy` is high is ignored. It causes no frame and no `done`.
- R10: With ADDR4=1, `busy` is 1 out of reset. The block sends the frame 0x06 and then the frame 0xB7, and then clears `busy`. Later program frames carry four address bytes taken from `addr[31:0]`.
- R11: `done` is high for exactly one cycle, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a write |
| addr | input | 32 | Flash byte address |
| wdata | input | 32 | Data bytes, low byte sent first |
| dlen | input | 2 | Number of data bytes minus one |
| busy | output | 1 | Sequence or start-up commands in progress |
| done | output | 1 | One-cycle end-of-write pulse |
| result | output | 2 | 00 ok, 01 timeout, 10 write-enable latch error |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds two instances. Both use CLK_DIV=2, CS_GAP_TICKS=3, PROG_MAX_CYC=200 and TO_SCALE_X10=25. One uses 3-byte addressing and the other uses ADDR4=1. The short 500-cycle timeout lets a device that never finishes reach the timeout path in a few status polls, so its timing window can be measured. The fast divider keeps every frame short enough to test all four data lengths, several busy-poll counts and the stuck write-enable latch case. The second instance exposes the start-up command pair and the four-byte address layout.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;
  typedef enum logic [1:0] {RES_OK = 2'b00, RES_TIMEOUT = 2'b01, RES_WEL_ERR = 2'b10} result_t;
  typedef enum logic [1:0] {FR_WREN, FR_EN4B, FR_PROG, FR_RDSR} frame_t;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_EN4B = 8'hB7;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       active,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] div_cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    sh;
  logic          tick;

  assign tick = (div_cnt == CW'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt   <= '0;
      bit_idx   <= '0;
      sh        <= '0;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      active    <= 1'b0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (go && !active) begin
        active  <= 1'b1;
        sh      <= tx_byte;
        mosi    <= tx_byte[7];
        div_cnt <= '0;
        bit_idx <= '0;
        sclk    <= 1'b0;
      end else if (active) begin
        if (tick) begin
          div_cnt <= '0;
          if (!sclk) begin
            sclk    <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bit_idx == 3'd7) begin
              active    <= 1'b0;
              byte_done <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 3'd1;
              sh      <= {sh[6:0], 1'b0};
              mosi    <= sh[6];
            end
          end
        end else begin
          div_cnt <= div_cnt + CW'(1);
        end
      end
    end
  end

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst) go |-> !active); // R4
  AST_DONE_ENDS_BYTE: assert property (@(posedge clk) disable iff (rst) byte_done |-> !active && !sclk); // R4
endmodule

// File: rtl/spi_poll_timer.sv
module spi_poll_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  assign expired = (cnt == TW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (!expired) cnt <= cnt + TW'(1);
  end

  AST_EXPIRY_STICKS: assert property (@(posedge clk) disable iff (rst) (expired && !clear) |=> expired); // R6
endmodule

// File: rtl/spi_prog_ctrl.sv
module spi_prog_ctrl
  import spi_prog_pkg::*;
#(
  parameter bit ADDR4   = 1'b0,
  parameter int GAP_CYC = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  input  logic [1:0]  dlen,
  output logic        busy,
  output logic        done,
  output logic [1:0]  result,
  output logic        cs_n,
  output logic        go,
  output logic [7:0]  tx_byte,
  input  logic        byte_done,
  input  logic        byte_active,
  input  logic [7:0]  rx_byte,
  output logic        tmr_clear,
  input  logic        tmr_expired
);
  localparam int AB = ADDR4 ? 4 : 3;
  localparam int GW = $clog2(GAP_CYC + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_GAP, ST_LAUNCH, ST_XFER, ST_NEXT} state_t;

  state_t        state;
  frame_t        frame;
  logic          init_ph;
  logic [3:0]    idx;
  logic [3:0]    len;
  logic [31:0]   addr_q;
  logic [31:0]   data_q;
  logic [1:0]    dlen_q;
  logic [7:0]    status_q;
  logic [GW-1:0] gap_cnt;
  logic [7:0]    tx_next;

  always_comb begin
    tx_next = 8'h00;
    unique case (frame)
      FR_WREN: tx_next = OP_WREN;
      FR_EN4B: tx_next = OP_EN4B;
      FR_RDSR: tx_next = (idx == 4'd0) ? OP_RDSR : 8'h00;
      FR_PROG: begin
        if (idx == 4'd0)            tx_next = OP_PROG;
        else if (int'(idx) <= AB)   tx_next = 8'(addr_q >> (8 * (AB - int'(idx))));
        else                        tx_next = 8'(data_q >> (8 * (int'(idx) - 1 - AB)));
      end
      default: tx_next = 8'h00;
    endcase
  end

  assign tmr_clear = (state == ST_NEXT) && (frame == FR_PROG);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ADDR4 ? ST_GAP : ST_IDLE;
      frame    <= FR_WREN;
      init_ph  <= ADDR4;
      busy     <= ADDR4;
      done     <= 1'b0;
      result   <= RES_OK;
      cs_n     <= 1'b1;
      go       <= 1'b0;
      tx_byte  <= '0;
      idx      <= '0;
      len      <= 4'd1;
      addr_q   <= '0;
      data_q   <= '0;
      dlen_q   <= '0;
      status_q <= '0;
      gap_cnt  <= '0;
    end else begin
      done <= 1'b0;
      go   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            addr_q  <= addr;
            data_q  <= wdata;
            dlen_q  <= dlen;
            frame   <= FR_WREN;
            len     <= 4'd1;
            idx     <= '0;
            gap_cnt <= '0;
            busy    <= 1'b1;
            state   <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GW'(GAP_CYC - 1)) begin
            cs_n  <= 1'b0;
            state <= ST_LAUNCH;
          end else begin
            gap_cnt <= gap_cnt + GW'(1);
          end
        end
        ST_LAUNCH: begin
          go      <= 1'b1;
          tx_byte <= tx_next;
          state   <= ST_XFER;
        end
        ST_XFER: begin
          if (byte_done) begin
            if (idx == len - 4'd1) begin
              cs_n     <= 1'b1;
              status_q <= rx_byte;
              state    <= ST_NEXT;
            end else begin
              idx   <= idx + 4'd1;
              state <= ST_LAUNCH;
            end
          end
        end
        ST_NEXT: begin
          idx     <= '0;
          gap_cnt <= '0;
          state   <= ST_GAP;
          unique case (frame)
            FR_WREN: begin
              if (init_ph) begin
                frame <= FR_EN4B;
                len   <= 4'd1;
              end else begin
                frame <= FR_PROG;
                len   <= 4'(2 + AB + int'(dlen_q));
              end
            end
            FR_EN4B: begin
              init_ph <= 1'b0;
              busy    <= 1'b0;
              state   <= ST_IDLE;
            end
            FR_PROG: begin
              frame <= FR_RDSR;
              len   <= 4'd2;
            end
            default: begin
              if (!status_q[0]) begin
                done   <= 1'b1;
                busy   <= 1'b0;
                result <= status_q[1] ? RES_WEL_ERR : RES_OK;
                state  <= ST_IDLE;
              end else if (tmr_expired) begin
                done   <= 1'b1;
                busy   <= 1'b0;
                result <= RES_TIMEOUT;
                state  <= ST_IDLE;
              end
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // cycles with chip select high, for the gap property
  logic [GW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst || !cs_n) hi_cnt <= '0;
    else if (hi_cnt != GW'(GAP_CYC)) hi_cnt <= hi_cnt + GW'(1);
  end

  AST_CS_WHOLE_BYTES: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> !byte_active); // R4
  AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (rst) $fell(cs_n) |-> (int'($past(hi_cnt)) + 1 >= GAP_CYC)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R11
  AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (rst) !$stable(result) |-> done); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst) (busy && start) |=> $stable(addr_q)); // R9
endmodule

// File: rtl/spi_nor_prog_seq.sv
module spi_nor_prog_seq #(
  parameter int CLK_DIV      = 4,
  parameter int CS_GAP_TICKS = 2,
  parameter int PROG_MAX_CYC = 1000000,
  parameter int TO_SCALE_X10 = 30,
  parameter bit ADDR4        = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  input  logic [1:0]  dlen,
  output logic        busy,
  output logic        done,
  output logic [1:0]  result,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int GAP_CYC = CS_GAP_TICKS * CLK_DIV;
  localparam int TO_CYC  = (PROG_MAX_CYC * TO_SCALE_X10) / 10;

  logic       go, byte_done, byte_active, tmr_clear, tmr_expired;
  logic [7:0] tx_byte, rx_byte;

  spi_prog_ctrl #(.ADDR4(ADDR4), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .addr(addr), .wdata(wdata), .dlen(dlen),
    .busy(busy), .done(done), .result(result), .cs_n(spi_cs_n),
    .go(go), .tx_byte(tx_byte), .byte_done(byte_done), .byte_active(byte_active),
    .rx_byte(rx_byte), .tmr_clear(tmr_clear), .tmr_expired(tmr_expired)
  );

  spi_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .go(go), .tx_byte(tx_byte), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .active(byte_active),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  spi_poll_timer #(.LIMIT(TO_CYC)) u_timer (
    .clk(clk), .rst(rst), .clear(tmr_clear), .expired(tmr_expired)
  );

  AST_SCLK_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (rst) spi_cs_n |-> !spi_sclk); // R4
endmodule

// File: tb/sim_flash_model.sv
`timescale 1ns/1ps
module sim_flash_model (
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic miso
);
  int         busy_reads = 0;
  bit         wel_stuck  = 0;
  int         nfr = 0;
  int         flen  [0:63];
  bit         fpart [0:63];
  logic [7:0] fbytes [0:63][0:9];
  time        trise [0:63];
  time        t_last_rise = 0;
  longint     min_gap_ns = 64'd1000000000;
  bit         in_frame = 0;
  int         bits = 0;
  int         wip_left = 0;
  bit         wel = 0;
  logic [7:0] sh = 0;
  logic [7:0] stat;

  initial miso = 1'b0;

  task automatic clear_log();
    nfr = 0;
  endtask

  always @(negedge cs_n) begin
    if (nfr > 0 && ($time - t_last_rise) < min_gap_ns) min_gap_ns = $time - t_last_rise;
    bits = 0;
    in_frame = 1;
  end

  always @(posedge sclk) begin
    if (in_frame && !cs_n) begin
      sh = {sh[6:0], mosi};
      bits++;
      if ((bits % 8) == 0 && bits / 8 <= 10 && nfr < 64) fbytes[nfr][bits/8 - 1] = sh;
    end
  end

  always @(negedge sclk) begin
    if (in_frame && !cs_n && bits >= 8 && nfr < 64 && fbytes[nfr][0] == 8'h05) begin
      stat = {6'b0, wel, (wip_left > 0)};
      miso = stat[7 - ((bits - 8) % 8)];
    end
  end

  always @(posedge cs_n) begin
    if (in_frame) begin
      in_frame = 0;
      if (nfr < 64) begin
        flen[nfr]  = bits / 8;
        fpart[nfr] = (bits % 8) != 0;
        trise[nfr] = $time;
        case (fbytes[nfr][0])
          8'h06: wel = 1;
          8'h02: if (wel) begin wip_left = busy_reads; wel = wel_stuck; end
          8'h05: if (wip_left > 0) wip_left--;
          default: ;
        endcase
        nfr++;
      end
      t_last_rise = $time;
    end
  end
endmodule

// File: tb/sim_spi_nor_prog_seq.sv
`timescale 1ns/1ps
module sim_spi_nor_prog_seq;
  localparam int CLK_DIV = 2, CS_GAP_TICKS = 3, PROG_MAX_CYC = 200, TO_SCALE_X10 = 25;
  localparam int GAP_CYC = CS_GAP_TICKS * CLK_DIV;
  localparam int TO_CYC  = PROG_MAX_CYC * TO_SCALE_X10 / 10;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] d;
    logic [1:0]  n;
    logic [15:0] br;
    logic        wel;
    logic [1:0]  res;
  } vec_t;

  localparam vec_t VEC [0:4] = '{
    '{32'h0012_3456, 32'h0000_00A5, 2'd0, 16'd0,    1'b0, 2'b00},
    '{32'h00AB_CDEF, 32'h4433_2211, 2'd3, 16'd3,    1'b0, 2'b00},
    '{32'h00FF_FF00, 32'h0000_BEEF, 2'd1, 16'd1,    1'b1, 2'b10},
    '{32'h0000_0001, 32'h00C0_FFEE, 2'd2, 16'd1000, 1'b0, 2'b01},
    '{32'h0080_0000, 32'h5A5A_5A5A, 2'd3, 16'd5,    1'b0, 2'b00}
  };

  logic clk = 0, rst = 1, start0 = 0, start1 = 0;
  logic [31:0] addr = 0, wdata = 0;
  logic [1:0]  dlen = 0;
  logic busy0, done0, busy1, done1, cs0, sclk0, mosi0, miso0, cs1, sclk1, mosi1, miso1;
  logic [1:0] res0, res1;
  int total = 0, bad = 0;
  time t_done;

  always #2.5 clk = ~clk;

  spi_nor_prog_seq #(.CLK_DIV(CLK_DIV), .CS_GAP_TICKS(CS_GAP_TICKS), .PROG_MAX_CYC(PROG_MAX_CYC),
                     .TO_SCALE_X10(TO_SCALE_X10), .ADDR4(1'b0)) u0 (
    .clk(clk), .rst(rst), .start(start0), .addr(addr), .wdata(wdata), .dlen(dlen),
    .busy(busy0), .done(done0), .result(res0), .spi_cs_n(cs0), .spi_sclk(sclk0),
    .spi_mosi(mosi0), .spi_miso(miso0));
  sim_flash_model fm0 (.cs_n(cs0), .sclk(sclk0), .mosi(mosi0), .miso(miso0));

  spi_nor_prog_seq #(.CLK_DIV(CLK_DIV), .CS_GAP_TICKS(CS_GAP_TICKS), .PROG_MAX_CYC(PROG_MAX_CYC),
                     .TO_SCALE_X10(TO_SCALE_X10), .ADDR4(1'b1)) u1 (
    .clk(clk), .rst(rst), .start(start1), .addr(addr), .wdata(wdata), .dlen(dlen),
    .busy(busy1), .done(done1), .result(res1), .spi_cs_n(cs1), .spi_sclk(sclk1),
    .spi_mosi(mosi1), .spi_miso(miso1));
  sim_flash_model fm1 (.cs_n(cs1), .sclk(sclk1), .mosi(mosi1), .miso(miso1));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done0();
    do @(negedge clk); while (!done0);
    t_done = $time;
  endtask

  task automatic kick0(input logic [31:0] a, input logic [31:0] d, input logic [1:0] n);
    @(negedge clk);
    addr = a; wdata = d; dlen = n; start0 = 1;
    @(negedge clk);
    start0 = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(cs0 == 1 && sclk0 == 0, "R1", "cs_n/sclk after reset", {cs0, sclk0}, 2'b10);
    chk(busy0 == 0 && done0 == 0 && res0 == 0, "R1", "busy/done/result after reset",
        {busy0, done0, res0}, 0);
    // R10 start-up commands
    chk(busy1 == 1, "R10", "busy out of reset", busy1, 1);
    do @(negedge clk); while (busy1);
    chk(fm1.nfr == 2, "R10", "start-up frame count", fm1.nfr, 2);
    chk(fm1.fbytes[0][0] == 8'h06 && fm1.flen[0] == 1, "R10", "first start-up frame",
        fm1.fbytes[0][0], 8'h06);
    chk(fm1.fbytes[1][0] == 8'hB7 && fm1.flen[1] == 1, "R10", "second start-up frame",
        fm1.fbytes[1][0], 8'hB7);

    // table walk on the 3-byte instance
    for (int i = 0; i < 5; i++) begin
      automatic vec_t v = VEC[i];
      automatic bit ok = 1;
      automatic bit rd_ok = 1;
      automatic longint el;
      fm0.busy_reads = int'(v.br);
      fm0.wel_stuck  = v.wel;
      fm0.clear_log();
      kick0(v.a, v.d, v.n);
      wait_done0();
      chk(busy0 == 0, "R11", "busy during done", busy0, 0);
      chk(res0 == v.res, (v.res == 2'b01) ? "R6" : "R7", "result code", res0, v.res);
      @(negedge clk);
      chk(done0 == 0, "R11", "done width", done0, 0);
      chk(fm0.fbytes[0][0] == 8'h06 && fm0.flen[0] == 1, "R2", "write-enable frame",
          {fm0.fbytes[0][0], 8'(fm0.flen[0])}, 16'h0601);
      chk(fm0.fbytes[1][0] == 8'h02 && fm0.flen[1] == 5 + int'(v.n), "R3", "program opcode/length",
          {fm0.fbytes[1][0], 8'(fm0.flen[1])}, {8'h02, 8'(5 + int'(v.n))});
      for (int k = 0; k < 3; k++) if (fm0.fbytes[1][1+k] != v.a[8*(2-k) +: 8]) ok = 0;
      for (int k = 0; k <= int'(v.n); k++) if (fm0.fbytes[1][4+k] != v.d[8*k +: 8]) ok = 0;
      chk(ok, "R3", "program address/data bytes", {fm0.fbytes[1][1], fm0.fbytes[1][4]},
          {v.a[23:16], v.d[7:0]});
      ok = 1;
      for (int f = 0; f < fm0.nfr; f++) if (fm0.fpart[f]) ok = 0;
      chk(ok, "R4", "frames end on byte boundary", ok, 1);
      for (int f = 2; f < fm0.nfr; f++) if (fm0.fbytes[f][0] != 8'h05 || fm0.flen[f] != 2) rd_ok = 0;
      chk(rd_ok && fm0.nfr >= 3, "R5", "status frames form", fm0.nfr, 3);
      if (v.res != 2'b01) begin
        chk(fm0.nfr == 3 + int'(v.br), "R5", "status frame count", fm0.nfr, 3 + int'(v.br));
      end else begin
        el = longint'((t_done - fm0.trise[1]) / 5);
        chk(el >= TO_CYC && el <= TO_CYC + 150, "R6", "timeout window cycles", el, TO_CYC);
      end
    end
    chk(fm0.min_gap_ns >= GAP_CYC * 5, "R8", "minimum cs high ns", fm0.min_gap_ns, GAP_CYC * 5);

    // R9: second start while busy is ignored
    begin
      automatic int dones = 0;
      automatic int progs = 0;
      fm0.busy_reads = 4; fm0.wel_stuck = 0;
      fm0.clear_log();
      kick0(32'h0013_5790, 32'h77, 2'd0);
      repeat (150) @(negedge clk);
      addr = 32'h0024_6800; start0 = 1;
      @(negedge clk);
      start0 = 0;
      repeat (1500) begin
        @(negedge clk);
        if (done0) dones++;
      end
      for (int f = 0; f < fm0.nfr; f++) if (fm0.fbytes[f][0] == 8'h02) progs++;
      chk(dones == 1, "R9", "done count", dones, 1);
      chk(progs == 1 && fm0.fbytes[1][1] == 8'h13 && fm0.fbytes[1][3] == 8'h90, "R9",
          "only first program frame", {8'(progs), fm0.fbytes[1][1]}, {8'd1, 8'h13});
      chk(res0 == 2'b00, "R7", "ok result", res0, 0);
    end

    // R10: 4-byte program frame on second instance
    fm1.clear_log();
    @(negedge clk);
    addr = 32'h1234_5678; wdata = 32'h99; dlen = 0; start1 = 1;
    @(negedge clk);
    start1 = 0;
    do @(negedge clk); while (!done1);
    chk(fm1.fbytes[1][0] == 8'h02 && fm1.flen[1] == 6, "R10", "4-byte program length",
        fm1.flen[1], 6);
    chk(fm1.fbytes[1][1] == 8'h12 && fm1.fbytes[1][2] == 8'h34 && fm1.fbytes[1][3] == 8'h56 &&
        fm1.fbytes[1][4] == 8'h78 && fm1.fbytes[1][5] == 8'h99, "R10", "4-byte address bytes",
        {fm1.fbytes[1][1], fm1.fbytes[1][4], fm1.fbytes[1][5]}, 24'h127899);
    chk(res1 == 2'b00, "R7", "4-byte result", res1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule